// File: doc/BRIEF.md
# Legacy INTx Message Aggregator

This block turns level-sensitive interrupt requests from up to eight functions into legacy virtual-wire interrupt messages. Each function selects one of four shared virtual wires (A, B, C or D) through its own interrupt-pin setting. A per-function disable bit can remove the function from its wire. The requests that land on the same wire are ORed together. The block sends an Assert message when a wire's ORed state rises and a Deassert message when it falls.

Each wire keeps a record of the last state it announced. A message is produced only when the live ORed state differs from that record. A request that rises and falls while the message port is stalled therefore leaves no trace. Messages leave one at a time on a ready/valid port. When several wires need one at once, the lowest wire letter goes first. A separate registered status vector mirrors every function's raw request level for the function status registers.

Top module: `intx_msg_agg`

## Requirements
- R1: `func_irq_sts[k]` equals the level of `irq_lvl[k]` sampled at the previous clock edge. It is affected by neither the pin setting nor the disable bit.
- R2: Function k's 3-bit pin field `pin_cfg[3k+2:3k]` selects its wire: 1 selects A, 2 selects B, 3 selects C and 4 selects D, reported on `msg_wire` as 0, 1, 2 and 3. The values 0 and 5 to 7 make the function's request produce no message.
- R3: When `irq_dis[k]` is 1, function k contributes nothing to its wire, and raising or lowering its request produces no message.
- R4: The state of a wire is the OR of all enabled requests routed to it. While another request on the same wire is already high, raising or lowering a request produces no message. Only the first rise of the OR and the final fall of the OR produce messages.
- R5: `msg_assert` is 1 for an Assert message and 0 for a Deassert message. A wire is announced only when its live state differs from its last announced state. As a result, a request that rises and falls while the port is stalled produces no message.
- R6: When the port is idle with `msg_ready` high, `msg_valid` rises two clock edges after the input change that caused it. The input is registered at the first edge and the message is registered at the second.
- R7: While `msg_valid` is 1 and `msg_ready` is 0, `msg_valid`, `msg_wire` and `msg_assert` hold their values.
- R8: Pending messages leave one per handshake in the fixed order A, B, C, D.
- R9: In reset, `msg_valid` and `func_irq_sts` are 0 and every wire's record is deasserted. A request that is already high when reset is released is therefore announced with an Assert message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lvl | input | NUM_FUNC | Level interrupt request per function |
| pin_cfg | input | 3*NUM_FUNC | Interrupt-pin setting per function |
| irq_dis | input | NUM_FUNC | Interrupt disable per function |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Consumer accepts message |
| msg_assert | output | 1 | 1 = Assert, 0 = Deassert |
| msg_wire | output | 2 | Wire index, 0 = A to 3 = D |
| func_irq_sts | output | NUM_FUNC | Registered request level per function |

## Verification
The hardest situation to reach from the ports is a request that rises and falls without ever being announced. It requires the message port to be busy for the whole life of the pulse. The bench holds `msg_ready` low while an Assert for wire A is parked on the port. It then pulses a request on wire B for one cycle and releases the port. Only the wire-A message may appear. The same stalled-port technique queues all four wires at once to expose the priority order.

// File: rtl/intx_pkg.sv
package intx_pkg;
   localparam int unsigned NUM_WIRES = 4;
   localparam int unsigned PIN_W     = 3;
   localparam int unsigned WIRE_W    = $clog2(NUM_WIRES);

   typedef enum logic [WIRE_W-1:0] {
      WIRE_A = 2'd0,
      WIRE_B = 2'd1,
      WIRE_C = 2'd2,
      WIRE_D = 2'd3
   } wire_e;

   // pin setting to one-hot wire select; out-of-range codes select nothing
   function automatic logic [NUM_WIRES-1:0] pin_to_wire(input logic [PIN_W-1:0] pin);
      logic [NUM_WIRES-1:0] sel;
      sel = '0;
      for (int w = 0; w < NUM_WIRES; w++) begin
         if (pin == PIN_W'(w + 1)) sel[w] = 1'b1;
      end
      return sel;
   endfunction
endpackage

// File: rtl/intx_route.sv
module intx_route
   import intx_pkg::*;
#(
   parameter int unsigned NUM_FUNC = 8
) (
   input  logic [NUM_FUNC-1:0]       lvl,
   input  logic [NUM_FUNC*PIN_W-1:0] pin,
   input  logic [NUM_FUNC-1:0]       dis,
   output logic [NUM_WIRES-1:0]      wire_or
);
   logic [NUM_WIRES-1:0] contrib [NUM_FUNC];

   for (genvar f = 0; f < NUM_FUNC; f++) begin : g_func
      always_comb begin
         contrib[f] = '0;
         if (lvl[f] && !dis[f]) contrib[f] = pin_to_wire(pin[f*PIN_W +: PIN_W]);
      end
   end

   always_comb begin
      wire_or = '0;
      for (int f = 0; f < NUM_FUNC; f++) wire_or = wire_or | contrib[f];
   end
endmodule

// File: rtl/intx_wire_rec.sv
module intx_wire_rec (
   input  logic clk,
   input  logic rst_n,
   input  logic cur,
   input  logic load,
   output logic rec,
   output logic need
);
   always_ff @(posedge clk) begin
      if (!rst_n)    rec <= 1'b0;
      else if (load) rec <= cur;
   end

   assign need = cur ^ rec;

   // a committed message always flips the recorded state
   AST_LOAD_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> rec != $past(rec)); // R5
endmodule

// File: rtl/intx_msg_arb.sv
module intx_msg_arb
   import intx_pkg::*;
#(
   parameter int unsigned NW = NUM_WIRES
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NW-1:0]         need,
   input  logic [NW-1:0]         cur,
   input  logic                  msg_ready,
   output logic [NW-1:0]         load,
   output logic                  msg_valid,
   output logic [$clog2(NW)-1:0] msg_wire,
   output logic                  msg_assert
);
   localparam int unsigned IW = $clog2(NW);

   logic [NW-1:0] pick;
   logic          found;
   logic [IW-1:0] idx;
   logic          lvl_sel;
   logic          out_free;

   always_comb begin
      pick    = '0;
      found   = 1'b0;
      idx     = '0;
      lvl_sel = 1'b0;
      for (int i = 0; i < NW; i++) begin
         if (need[i] && !found) begin
            pick[i] = 1'b1;
            found   = 1'b1;
            idx     = IW'(i);
            lvl_sel = cur[i];
         end
      end
   end

   assign out_free = !msg_valid || msg_ready;
   assign load     = out_free ? pick : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         msg_valid  <= 1'b0;
         msg_wire   <= '0;
         msg_assert <= 1'b0;
      end else if (out_free) begin
         msg_valid <= found;
         if (found) begin
            msg_wire   <= idx;
            msg_assert <= lvl_sel;
         end
      end
   end

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid && !msg_ready |=> msg_valid && $stable(msg_wire) && $stable(msg_assert)); // R7
   AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(load)); // R8
   AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (out_free && need[0]) |=> msg_valid && msg_wire == '0); // R8
endmodule

// File: rtl/intx_msg_agg.sv
module intx_msg_agg
   import intx_pkg::*;
#(
   parameter int unsigned NUM_FUNC   = 8,
   parameter bit          REG_INPUTS = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_FUNC-1:0]        irq_lvl,
   input  logic [NUM_FUNC*PIN_W-1:0]  pin_cfg,
   input  logic [NUM_FUNC-1:0]        irq_dis,
   output logic                       msg_valid,
   input  logic                       msg_ready,
   output logic                       msg_assert,
   output logic [WIRE_W-1:0]          msg_wire,
   output logic [NUM_FUNC-1:0]        func_irq_sts
);
   if (NUM_FUNC < 1 || NUM_FUNC > 8) begin : g_bad_cfg
      $error("intx_msg_agg: NUM_FUNC must lie in 1..8");
   end

   logic [NUM_FUNC-1:0]  lvl_q;
   logic [NUM_WIRES-1:0] wire_or;
   logic [NUM_WIRES-1:0] rec;
   logic [NUM_WIRES-1:0] need;
   logic [NUM_WIRES-1:0] load;
   logic                 past_ok;

   if (REG_INPUTS) begin : g_in_reg
      always_ff @(posedge clk) begin
         if (!rst_n) lvl_q <= '0;
         else        lvl_q <= irq_lvl;
      end
   end else begin : g_in_comb
      assign lvl_q = irq_lvl;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         func_irq_sts <= '0;
         past_ok      <= 1'b0;
      end else begin
         func_irq_sts <= irq_lvl;
         past_ok      <= 1'b1;
      end
   end

   intx_route #(.NUM_FUNC(NUM_FUNC)) u_route (
      .lvl     (lvl_q),
      .pin     (pin_cfg),
      .dis     (irq_dis),
      .wire_or (wire_or)
   );

   for (genvar w = 0; w < NUM_WIRES; w++) begin : g_wire
      intx_wire_rec u_rec (
         .clk   (clk),
         .rst_n (rst_n),
         .cur   (wire_or[w]),
         .load  (load[w]),
         .rec   (rec[w]),
         .need  (need[w])
      );
   end

   intx_msg_arb #(.NW(NUM_WIRES)) u_arb (
      .clk        (clk),
      .rst_n      (rst_n),
      .need       (need),
      .cur        (wire_or),
      .msg_ready  (msg_ready),
      .load       (load),
      .msg_valid  (msg_valid),
      .msg_wire   (msg_wire),
      .msg_assert (msg_assert)
   );

   AST_MSG_MATCH_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> msg_assert == rec[msg_wire]); // R5
   AST_STS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> func_irq_sts == $past(irq_lvl)); // R1
endmodule

// File: tb/tb_intx_msg_agg.sv
`timescale 1ns/1ps
module tb_intx_msg_agg;
   localparam int NF = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [NF-1:0] irq_lvl;
   logic [NF*3-1:0] pin_cfg;
   logic [NF-1:0] irq_dis;
   logic          msg_valid, msg_ready, msg_assert;
   logic [1:0]    msg_wire;
   logic [NF-1:0] func_irq_sts;

   int checks = 0;
   int fails  = 0;
   logic [2:0] log_e [0:1023];
   int log_n = 0;

   always #4 clk = ~clk;

   intx_msg_agg dut (
      .clk(clk), .rst_n(rst_n), .irq_lvl(irq_lvl), .pin_cfg(pin_cfg),
      .irq_dis(irq_dis), .msg_valid(msg_valid), .msg_ready(msg_ready),
      .msg_assert(msg_assert), .msg_wire(msg_wire), .func_irq_sts(func_irq_sts)
   );

   // handshake monitor, sampled away from the active edge
   always @(negedge clk) begin
      if (rst_n === 1'b1 && msg_valid && msg_ready && log_n < 1024) begin
         log_e[log_n] = {msg_assert, msg_wire};
         log_n = log_n + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic summary;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      #(200000 * 8);
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
   end

   initial begin
      int base;
      rst_n = 1'b0; irq_lvl = '0; pin_cfg = '0; irq_dis = '0; msg_ready = 1'b1;
      // R9: request already high through reset
      pin_cfg[2:0] = 3'd1; irq_lvl[0] = 1'b1;
      tick(3);
      @(negedge clk);
      chk(msg_valid == 1'b0, "R9 valid in reset", msg_valid, 0);
      chk(func_irq_sts == '0, "R9 status in reset", func_irq_sts, 0);
      base = log_n;
      @(posedge clk); #1 rst_n = 1'b1;
      tick(5);
      chk(log_n - base == 1, "R9 count", log_n - base, 1);
      chk(log_e[base] == 3'b100, "R9 assert A", log_e[base], 4);
      irq_lvl = '0; tick(5);
      pin_cfg = '0;

      // R2/R3/R1 sweep: every function, every pin code, both disable values
      for (int f = 0; f < NF; f++) begin
         for (int p = 0; p < 8; p++) begin
            for (int d = 0; d < 2; d++) begin
               bit en;
               en = (p >= 1 && p <= 4 && d == 0);
               pin_cfg = '0; irq_dis = '0;
               pin_cfg[f*3 +: 3] = 3'(p); irq_dis[f] = 1'(d);
               tick(1);
               base = log_n;
               irq_lvl[f] = 1'b1;
               tick(4);
               chk(func_irq_sts == NF'(1 << f), "R1 status high", func_irq_sts, 1 << f);
               irq_lvl[f] = 1'b0;
               tick(4);
               chk(func_irq_sts == '0, "R1 status low", func_irq_sts, 0);
               if (en) begin
                  chk(log_n - base == 2, "R2 msg count", log_n - base, 2);
                  chk(log_e[base] == {1'b1, 2'(p - 1)}, "R2 assert wire", log_e[base], 4 + p - 1);
                  chk(log_e[base+1] == {1'b0, 2'(p - 1)}, "R2 deassert wire", log_e[base+1], p - 1);
               end else if (d == 1) begin
                  chk(log_n - base == 0, "R3 disabled silent", log_n - base, 0);
               end else begin
                  chk(log_n - base == 0, "R2 no-pin silent", log_n - base, 0);
               end
            end
         end
      end
      irq_dis = '0;

      // R6: latency from input change to msg_valid
      pin_cfg = '0; pin_cfg[5:3] = 3'd3;
      tick(1);
      irq_lvl[1] = 1'b1;
      @(negedge clk); @(negedge clk);
      chk(msg_valid == 1'b0, "R6 not after one edge", msg_valid, 0);
      @(negedge clk);
      chk(msg_valid == 1'b1, "R6 valid after two edges", msg_valid, 1);
      chk(msg_wire == 2'd2, "R6 wire C", msg_wire, 2);
      tick(1); irq_lvl = '0; tick(4);

      // R4: two functions sharing wire B
      pin_cfg = '0; pin_cfg[2:0] = 3'd2; pin_cfg[17:15] = 3'd2;
      tick(1); base = log_n;
      irq_lvl[0] = 1'b1; tick(4);
      irq_lvl[5] = 1'b1; tick(4);
      chk(log_n - base == 1, "R4 second rise silent", log_n - base, 1);
      irq_lvl[0] = 1'b0; tick(4);
      chk(log_n - base == 1, "R4 partial fall silent", log_n - base, 1);
      irq_lvl[5] = 1'b0; tick(4);
      chk(log_n - base == 2, "R4 final fall", log_n - base, 2);
      chk(log_e[base] == 3'b101 && log_e[base+1] == 3'b001, "R4 B pair", log_e[base+1], 1);

      // R8/R7: all four wires at once behind a stalled port
      pin_cfg = '0;
      for (int f = 0; f < 4; f++) pin_cfg[f*3 +: 3] = 3'(4 - f);
      msg_ready = 1'b0;
      tick(1); base = log_n;
      irq_lvl[3:0] = 4'hF;
      tick(3);
      @(negedge clk);
      chk(msg_valid && msg_wire == 2'd0 && msg_assert, "R7 parked A", msg_wire, 0);
      tick(3);
      @(negedge clk);
      chk(msg_valid && msg_wire == 2'd0 && msg_assert, "R7 held A", msg_wire, 0);
      msg_ready = 1'b1;
      tick(8);
      chk(log_n - base == 4, "R8 count", log_n - base, 4);
      for (int i = 0; i < 4; i++)
         chk(log_e[base+i] == {1'b1, 2'(i)}, "R8 order", log_e[base+i], 4 + i);
      irq_lvl = '0; tick(8);
      for (int i = 0; i < 4; i++)
         chk(log_e[base+4+i] == {1'b0, 2'(i)}, "R8 deassert order", log_e[base+4+i], i);

      // R5: short pulse on B while an A message is parked
      pin_cfg = '0; pin_cfg[2:0] = 3'd1; pin_cfg[5:3] = 3'd2;
      msg_ready = 1'b0;
      tick(1); base = log_n;
      irq_lvl[0] = 1'b1; tick(4);
      irq_lvl[1] = 1'b1; tick(1);
      irq_lvl[1] = 1'b0; tick(3);
      msg_ready = 1'b1; tick(6);
      chk(log_n - base == 1, "R5 pulse dropped", log_n - base, 1);
      chk(log_e[base] == 3'b100, "R5 only A", log_e[base], 4);
      irq_lvl = '0; tick(4);
      chk(log_n - base == 2 && log_e[base+1] == 3'b000, "R5 A deassert", log_n - base, 2);

      summary();
   end
endmodule